// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block decodes the bus write cycles aimed at a parallel NOR flash that uses the unlock-cycle command protocol. Each write carries a byte address and a data byte. The sequencer checks the two unlock cycles and latches the command that follows. It then reports the operating mode and issues single-cycle strobes that start a program or an erase in the storage and timing logic around it. Erase duration is owned by that outside logic. It reports the end of an erase through a done pulse. Programming is treated as immediate.

The block also contains the read-side selection for the identifier window. While the device is in identifier mode, reads at a few word offsets return identifier constants instead of array data. All other reads, and all reads in other modes, pass the array data through. The mode code also tells an outside query ROM when to drive the bus.

Top module: `nor_cmd_seq`

## Requirements
- R1: A synchronous active-high `rst` forces read mode (mode code 0), clears bypass and leaves both strobes low in the cycle after it.
- R2: The first unlock cycle must write 0xAA at unlock address A0, and the second must write 0x55 at unlock address A1. Any other first or second cycle returns to read mode with bypass cleared.
- R3: Only the low 11 bits of the word address are compared. With the 16-bit bus option, the word address is the byte address shifted right by one, so byte-address bit 0 and word bits above 10 are ignored.
- R4: The command cycle, written at A0, selects a mode: 0x80 gives erase setup (code 4), 0x90 gives identifier mode (code 1), 0xA0 gives program setup (code 3) and 0x20 gives bypass (code 6, `bypass_o`=1). Any other byte returns to read mode.
- R5: From erase setup, a second 0xAA/0x55 pair is required. Data 0x10 at A0 then pulses `erase_go` with `erase_chip`=1. Data 0x30 at any address pulses `erase_go` with `erase_chip`=0 and `erase_addr` equal to that byte address. Either one enters erase-running mode (code 5). 0x10 at any address other than A0 returns to read mode.
- R6: While an erase runs, every write is ignored, including 0xF0. An `erase_done` pulse returns the sequencer to read mode, or to bypass if bypass was set.
- R7: Data 0x98 at word address 0x55 enters query mode (code 2), from read mode or from identifier mode. A 0xF0 write in a query mode that was entered from identifier mode returns to identifier mode. Any other write in query mode returns to read mode.
- R8: Data 0xF0 returns to read mode from every mode except erase running and program setup. In program setup, 0xF0 is program data.
- R9: In bypass, the command cycle skips the address check. After each program the sequencer returns straight to bypass. An identifier command followed by data 0x00 leaves bypass for read mode.
- R10: A program pulses `prog_go` one cycle after its data write. `prog_addr` is the byte address of that write, and `prog_word` is `arr_cur AND wr_data`.
- R11: In identifier mode, reads at word offset 0, 1, 2, 0x0E and 0x0F (low 8 bits) return ID0, ID1, 0x00, ID2 and ID3. When ID2 or ID3 equals 0xFF, that offset returns array data instead. All other offsets return array data.
- R12: Outside identifier mode, `rd_data` equals `arr_rdata` at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| arr_cur | input | 8 | Array contents at `wr_addr`, same cycle |
| erase_done | input | 1 | Pulse from erase timing logic: erase finished |
| rd_addr | input | ADDR_W | Byte address of the read |
| arr_rdata | input | 8 | Array contents at `rd_addr` |
| rd_data | output | 8 | Read data after identifier selection |
| mode_o | output | 3 | 0 read, 1 identifier, 2 query, 3 program setup, 4 erase setup, 5 erase running, 6 bypass |
| bypass_o | output | 1 | Unlock bypass active |
| prog_go | output | 1 | Program strobe |
| prog_addr | output | ADDR_W | Program byte address |
| prog_word | output | 8 | Word to store (old AND new) |
| erase_go | output | 1 | Erase strobe |
| erase_chip | output | 1 | 1 chip erase, 0 sector erase |
| erase_addr | output | ADDR_W | Byte address inside the sector to erase |

## Verification
The assertions assume that `erase_done` pulses only while an erase is running, and that `arr_cur` holds the array word at the address being written. The bench raises `erase_done` only after a strobe has put the block into erase-running mode. It drives `arr_cur` as a chosen old value alongside each program write. The exhaustive sweeps cover every data byte in the first unlock cycle, in the command cycle and in the program merge, so each expected value comes from simple arithmetic on the swept byte.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
   localparam int DATA_W = 8;
   localparam int CMP_W  = 11;
   localparam int OFS_W  = 8;

   typedef enum logic [3:0] {
      ST_IDLE, ST_UNLK1, ST_CMDSEL, ST_PROG, ST_AUTOSEL,
      ST_ERS1, ST_ERS2, ST_ERS3, ST_ERASING, ST_CFI, ST_CFI_AS
   } seq_state_e;

   localparam logic [DATA_W-1:0] OP_UNLK_A   = 8'hAA;
   localparam logic [DATA_W-1:0] OP_UNLK_B   = 8'h55;
   localparam logic [DATA_W-1:0] OP_ERS_SET  = 8'h80;
   localparam logic [DATA_W-1:0] OP_IDENT    = 8'h90;
   localparam logic [DATA_W-1:0] OP_PROGRAM  = 8'hA0;
   localparam logic [DATA_W-1:0] OP_BYPASS   = 8'h20;
   localparam logic [DATA_W-1:0] OP_CHIP     = 8'h10;
   localparam logic [DATA_W-1:0] OP_SECTOR   = 8'h30;
   localparam logic [DATA_W-1:0] OP_QUERY    = 8'h98;
   localparam logic [DATA_W-1:0] OP_RESET    = 8'hF0;
   localparam logic [DATA_W-1:0] OP_BYP_EXIT = 8'h00;
   localparam logic [CMP_W-1:0]  QUERY_KEY   = 11'h055;

   localparam logic [2:0] MODE_READ  = 3'd0;
   localparam logic [2:0] MODE_IDENT = 3'd1;
   localparam logic [2:0] MODE_QUERY = 3'd2;
   localparam logic [2:0] MODE_PROG  = 3'd3;
   localparam logic [2:0] MODE_ESET  = 3'd4;
   localparam logic [2:0] MODE_ERUN  = 3'd5;
   localparam logic [2:0] MODE_BYP   = 3'd6;
endpackage

// File: rtl/nor_addr_norm.sv
module nor_addr_norm #(
   parameter int ADDR_W = 16,
   parameter bit BUS16  = 1'b1,
   parameter int OUT_W  = 11
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [OUT_W-1:0]  word_key
);
   generate
      if (BUS16) begin : g_x16
         logic unused_hi;
         assign word_key  = byte_addr[OUT_W:1];
         assign unused_hi = ^{byte_addr[0], byte_addr[ADDR_W-1:OUT_W+1]};
      end else begin : g_x8
         logic unused_hi;
         assign word_key  = byte_addr[OUT_W-1:0];
         assign unused_hi = ^byte_addr[ADDR_W-1:OUT_W];
      end
   endgenerate
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
   import nor_seq_pkg::*;
#(
   parameter int               ADDR_W    = 16,
   parameter logic [CMP_W-1:0] UNLOCK_A0 = 11'h555,
   parameter logic [CMP_W-1:0] UNLOCK_A1 = 11'h2AA
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CMP_W-1:0]  wr_key,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] arr_cur,
   input  logic              erase_done,
   output seq_state_e        st,
   output logic              byp,
   output logic              prog_go,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_word,
   output logic              erase_go,
   output logic              erase_chip,
   output logic [ADDR_W-1:0] erase_addr
);
   seq_state_e nxt_st;
   logic       nxt_byp, abort, do_prog, do_erase, do_chip;
   logic       hit0, hit1, hitq;

   assign hit0 = (wr_key == UNLOCK_A0);
   assign hit1 = (wr_key == UNLOCK_A1);
   assign hitq = (wr_key == QUERY_KEY);

   always_comb begin
      nxt_st   = st;
      nxt_byp  = byp;
      abort    = 1'b0;
      do_prog  = 1'b0;
      do_erase = 1'b0;
      do_chip  = 1'b0;
      if (st == ST_ERASING) begin
         if (erase_done) nxt_st = byp ? ST_CMDSEL : ST_IDLE;
      end else if (wr_en) begin
         if (st != ST_PROG && wr_data == OP_RESET) begin
            if (st == ST_CFI_AS) nxt_st = ST_AUTOSEL;
            else                 abort  = 1'b1;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (hitq && wr_data == OP_QUERY)       nxt_st = ST_CFI;
                  else if (hit0 && wr_data == OP_UNLK_A) nxt_st = ST_UNLK1;
                  else                                   abort  = 1'b1;
               end
               ST_UNLK1: begin
                  if (hit1 && wr_data == OP_UNLK_B) nxt_st = ST_CMDSEL;
                  else                              abort  = 1'b1;
               end
               ST_CMDSEL: begin
                  if (!byp && !hit0) abort = 1'b1;
                  else begin
                     case (wr_data)
                        OP_BYPASS:  nxt_byp = 1'b1;
                        OP_ERS_SET: nxt_st  = ST_ERS1;
                        OP_IDENT:   nxt_st  = ST_AUTOSEL;
                        OP_PROGRAM: nxt_st  = ST_PROG;
                        default:    abort   = 1'b1;
                     endcase
                  end
               end
               ST_PROG: begin
                  do_prog = 1'b1;
                  nxt_st  = byp ? ST_CMDSEL : ST_IDLE;
               end
               ST_AUTOSEL: begin
                  if (byp && wr_data == OP_BYP_EXIT)    abort  = 1'b1;
                  else if (hitq && wr_data == OP_QUERY) nxt_st = ST_CFI_AS;
                  else                                  abort  = 1'b1;
               end
               ST_ERS1: begin
                  if (hit0 && wr_data == OP_UNLK_A) nxt_st = ST_ERS2;
                  else                              abort  = 1'b1;
               end
               ST_ERS2: begin
                  if (hit1 && wr_data == OP_UNLK_B) nxt_st = ST_ERS3;
                  else                              abort  = 1'b1;
               end
               ST_ERS3: begin
                  if (hit0 && wr_data == OP_CHIP) begin
                     do_erase = 1'b1;
                     do_chip  = 1'b1;
                     nxt_st   = ST_ERASING;
                  end else if (wr_data == OP_SECTOR) begin
                     do_erase = 1'b1;
                     nxt_st   = ST_ERASING;
                  end else abort = 1'b1;
               end
               default: abort = 1'b1;
            endcase
         end
      end
      if (abort) begin
         nxt_st  = ST_IDLE;
         nxt_byp = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_IDLE;
         byp        <= 1'b0;
         prog_go    <= 1'b0;
         prog_addr  <= '0;
         prog_word  <= '0;
         erase_go   <= 1'b0;
         erase_chip <= 1'b0;
         erase_addr <= '0;
      end else begin
         st       <= nxt_st;
         byp      <= nxt_byp;
         prog_go  <= do_prog;
         erase_go <= do_erase;
         if (do_prog) begin
            prog_addr <= wr_addr;
            prog_word <= arr_cur & wr_data;
         end
         if (do_erase) begin
            erase_chip <= do_chip;
            erase_addr <= wr_addr;
         end
      end
   end
endmodule

// File: rtl/nor_id_mux.sv
module nor_id_mux
   import nor_seq_pkg::*;
#(
   parameter logic [DATA_W-1:0] ID0 = 8'h01,
   parameter logic [DATA_W-1:0] ID1 = 8'h22,
   parameter logic [DATA_W-1:0] ID2 = 8'hFF,
   parameter logic [DATA_W-1:0] ID3 = 8'hFF
) (
   input  logic              ident,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_e, slot_f;

   generate
      if (ID2 == 8'hFF) begin : g_e_arr
         assign slot_e = arr_rdata;
      end else begin : g_e_id
         assign slot_e = ID2;
      end
      if (ID3 == 8'hFF) begin : g_f_arr
         assign slot_f = arr_rdata;
      end else begin : g_f_id
         assign slot_f = ID3;
      end
   endgenerate

   always_comb begin
      rd_data = arr_rdata;
      if (ident) begin
         case (ofs)
            8'h00:   rd_data = ID0;
            8'h01:   rd_data = ID1;
            8'h02:   rd_data = '0;
            8'h0E:   rd_data = slot_e;
            8'h0F:   rd_data = slot_f;
            default: rd_data = arr_rdata;
         endcase
      end
   end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int               ADDR_W    = 16,
   parameter bit               BUS16     = 1'b1,
   parameter logic [CMP_W-1:0] UNLOCK_A0 = 11'h555,
   parameter logic [CMP_W-1:0] UNLOCK_A1 = 11'h2AA,
   parameter logic [7:0]       ID0       = 8'h01,
   parameter logic [7:0]       ID1       = 8'h22,
   parameter logic [7:0]       ID2       = 8'hFF,
   parameter logic [7:0]       ID3       = 8'hFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        arr_cur,
   input  logic              erase_done,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        arr_rdata,
   output logic [7:0]        rd_data,
   output logic [2:0]        mode_o,
   output logic              bypass_o,
   output logic              prog_go,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_word,
   output logic              erase_go,
   output logic              erase_chip,
   output logic [ADDR_W-1:0] erase_addr
);
   localparam int MIN_ADDR_W = CMP_W + 2;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_width
         $error("nor_cmd_seq: ADDR_W too small for the unlock compare");
      end
      if (UNLOCK_A0 == UNLOCK_A1) begin : g_bad_unlock
         $error("nor_cmd_seq: unlock addresses must differ");
      end
   endgenerate

   seq_state_e            st;
   logic [CMP_W-1:0]      wr_key;
   logic [OFS_W-1:0]      rd_ofs;

   nor_addr_norm #(.ADDR_W(ADDR_W), .BUS16(BUS16), .OUT_W(CMP_W)) u_wr_norm (
      .byte_addr(wr_addr), .word_key(wr_key));

   nor_addr_norm #(.ADDR_W(ADDR_W), .BUS16(BUS16), .OUT_W(OFS_W)) u_rd_norm (
      .byte_addr(rd_addr), .word_key(rd_ofs));

   nor_cmd_fsm #(.ADDR_W(ADDR_W), .UNLOCK_A0(UNLOCK_A0), .UNLOCK_A1(UNLOCK_A1)) u_fsm (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_key(wr_key), .wr_addr(wr_addr),
      .wr_data(wr_data), .arr_cur(arr_cur), .erase_done(erase_done),
      .st(st), .byp(bypass_o), .prog_go(prog_go), .prog_addr(prog_addr),
      .prog_word(prog_word), .erase_go(erase_go), .erase_chip(erase_chip),
      .erase_addr(erase_addr));

   always_comb begin
      case (st)
         ST_CMDSEL:                 mode_o = bypass_o ? MODE_BYP : MODE_READ;
         ST_PROG:                   mode_o = MODE_PROG;
         ST_AUTOSEL:                mode_o = MODE_IDENT;
         ST_ERS1, ST_ERS2, ST_ERS3: mode_o = MODE_ESET;
         ST_ERASING:                mode_o = MODE_ERUN;
         ST_CFI, ST_CFI_AS:         mode_o = MODE_QUERY;
         default:                   mode_o = MODE_READ;
      endcase
   end

   nor_id_mux #(.ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_idmux (
      .ident(mode_o == MODE_IDENT), .ofs(rd_ofs), .arr_rdata(arr_rdata),
      .rd_data(rd_data));
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
   import nor_seq_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic [7:0] arr_cur,
   input logic       erase_done,
   input logic [2:0] mode_o,
   input logic       bypass_o,
   input logic       prog_go,
   input logic [7:0] prog_word,
   input logic       erase_go
);
   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (mode_o == MODE_READ && !bypass_o && !prog_go && !erase_go)); // R1

   AST_PROG_FROM_SETUP: assert property (@(posedge clk) disable iff (rst)
      prog_go |-> $past(mode_o) == MODE_PROG); // R4

   AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (rst)
      erase_go |-> (mode_o == MODE_ERUN && $past(mode_o) == MODE_ESET)); // R5

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(prog_go && erase_go)); // R5

   AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_o == MODE_ERUN && !erase_done) |=> mode_o == MODE_ERUN); // R6

   AST_BYPASS_RETURN: assert property (@(posedge clk) disable iff (rst)
      (prog_go && bypass_o) |-> mode_o == MODE_BYP); // R9

   AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
      prog_go |-> (prog_word & ~$past(arr_cur)) == 8'h00); // R10
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
   .clk(clk), .rst(rst), .arr_cur(arr_cur), .erase_done(erase_done),
   .mode_o(mode_o), .bypass_o(bypass_o), .prog_go(prog_go),
   .prog_word(prog_word), .erase_go(erase_go));

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/100ps
module nor_cmd_seq_bench;
   localparam int         AW  = 14;
   localparam logic [12:0] UA0 = 13'h0555;
   localparam logic [12:0] UA1 = 13'h02AA;
   localparam logic [7:0] I0 = 8'h01, I1 = 8'hC4, I2 = 8'hFF, I3 = 8'h7E;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    arr_cur = '0;
   logic          erase_done = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    arr_rdata = '0;
   logic [7:0]    rd_data;
   logic [2:0]    mode_o;
   logic          bypass_o, prog_go, erase_go, erase_chip;
   logic [AW-1:0] prog_addr, erase_addr;
   logic [7:0]    prog_word;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nor_cmd_seq #(.ADDR_W(AW), .BUS16(1'b1), .UNLOCK_A0(11'h555), .UNLOCK_A1(11'h2AA),
                 .ID0(I0), .ID1(I1), .ID2(I2), .ID3(I3)) u_nor_cmd_seq (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .arr_cur(arr_cur), .erase_done(erase_done), .rd_addr(rd_addr),
      .arr_rdata(arr_rdata), .rd_data(rd_data), .mode_o(mode_o),
      .bypass_o(bypass_o), .prog_go(prog_go), .prog_addr(prog_addr),
      .prog_word(prog_word), .erase_go(erase_go), .erase_chip(erase_chip),
      .erase_addr(erase_addr));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // word address w, data d, old array contents c
   task automatic wr(input logic [12:0] w, input logic [7:0] d, input logic [7:0] c = 8'hFF);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {w, 1'b0}; wr_data = d; arr_cur = c;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(UA0, 8'hAA);
      wr(UA1, 8'h55);
   endtask

   task automatic to_read();
      wr(13'h0, 8'hF0);
   endtask

   function automatic logic [7:0] exp_id(input logic [7:0] o, input logic [7:0] a);
      case (o)
         8'h00: return I0;
         8'h01: return I1;
         8'h02: return 8'h00;
         8'h0E: return (I2 == 8'hFF) ? a : I2;
         8'h0F: return (I3 == 8'hFF) ? a : I3;
         default: return a;
      endcase
   endfunction

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk(mode_o == 3'd0 && !bypass_o && !prog_go && !erase_go, "R1", mode_o, 0);

      // R2 sweep first unlock byte
      for (int d = 0; d < 256; d++) begin
         wr(UA0, 8'(d));
         wr(UA1, 8'h55);
         wr(UA0, 8'h90);
         chk(mode_o == ((d == 8'hAA) ? 3'd1 : 3'd0), "R2", mode_o, (d == 8'hAA) ? 1 : 0);
         to_read();
      end
      // R2 wrong second cycle
      wr(UA0, 8'hAA); wr(UA1, 8'h56); wr(UA0, 8'h90);
      chk(mode_o == 3'd0, "R2", mode_o, 0);

      // R3 upper word bits ignored, byte bit 0 ignored, neighbour address rejected
      wr(UA0 | 13'h1800, 8'hAA); wr(UA1 | 13'h0800, 8'h55); wr(UA0 | 13'h1000, 8'h90);
      chk(mode_o == 3'd1, "R3", mode_o, 1);
      to_read();
      @(negedge clk); wr_en = 1'b1; wr_addr = {UA0, 1'b1}; wr_data = 8'hAA;
      @(negedge clk); wr_en = 1'b0;
      wr(UA1, 8'h55); wr(UA0, 8'h90);
      chk(mode_o == 3'd1, "R3", mode_o, 1);
      to_read();
      wr(UA0 + 13'd1, 8'hAA); wr(UA1, 8'h55); wr(UA0, 8'h90);
      chk(mode_o == 3'd0, "R3", mode_o, 0);

      // R4 sweep command byte; R8 F0 as program data
      for (int c = 0; c < 256; c++) begin
         logic [2:0] em;
         unlock();
         wr(UA0, 8'(c));
         case (c)
            8'h80: em = 3'd4;
            8'h90: em = 3'd1;
            8'hA0: em = 3'd3;
            8'h20: em = 3'd6;
            default: em = 3'd0;
         endcase
         chk(mode_o == em && bypass_o == (c == 8'h20), "R4", mode_o, em);
         wr(13'h0123, 8'hF0, 8'h3C);
         chk(prog_go == (c == 8'hA0), "R8", prog_go, c == 8'hA0);
         if (c == 8'hA0) chk(prog_word == 8'h30, "R8", prog_word, 8'h30);
         chk(mode_o == 3'd0 && !bypass_o, "R8", mode_o, 0);
      end
      // R4 command at wrong address
      unlock(); wr(UA1, 8'h90);
      chk(mode_o == 3'd0, "R4", mode_o, 0);

      // R10 program merge sweep
      for (int v = 0; v < 256; v++) begin
         logic [7:0] oldv;
         oldv = 8'(v * 37 + 11);
         unlock(); wr(UA0, 8'hA0);
         wr(13'(v + 16), 8'(v), oldv);
         chk(prog_go && prog_word == (oldv & 8'(v)) && prog_addr == AW'({13'(v + 16), 1'b0}),
             "R10", prog_word, oldv & 8'(v));
         chk(mode_o == 3'd0, "R10", mode_o, 0);
      end

      // R5 chip erase, R6 writes ignored
      unlock(); wr(UA0, 8'h80); unlock(); wr(UA0, 8'h10);
      chk(erase_go && erase_chip && mode_o == 3'd5, "R5", {erase_go, erase_chip}, 3);
      wr(UA0, 8'hF0);
      chk(mode_o == 3'd5, "R6", mode_o, 5);
      wr(UA0, 8'hAA);
      chk(mode_o == 3'd5 && !erase_go, "R6", mode_o, 5);
      @(negedge clk); erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
      chk(mode_o == 3'd0, "R6", mode_o, 0);
      // R5 sector erase at any address
      unlock(); wr(UA0, 8'h80); unlock(); wr(13'h0ABC, 8'h30);
      chk(erase_go && !erase_chip && erase_addr == 14'h1578, "R5", erase_addr, 14'h1578);
      @(negedge clk); erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
      // R5 chip erase at wrong address
      unlock(); wr(UA0, 8'h80); unlock(); wr(UA1, 8'h10);
      chk(mode_o == 3'd0 && !erase_go, "R5", mode_o, 0);
      // R5 second unlock missing
      unlock(); wr(UA0, 8'h80); wr(UA0, 8'h30);
      chk(mode_o == 3'd0 && !erase_go, "R5", mode_o, 0);

      // R7 query from read, any write leaves
      wr(13'h0055, 8'h98);
      chk(mode_o == 3'd2, "R7", mode_o, 2);
      wr(13'h0055, 8'h98);
      chk(mode_o == 3'd0, "R7", mode_o, 0);
      wr(13'h0055, 8'h98); to_read();
      chk(mode_o == 3'd0, "R7", mode_o, 0);
      // R7 query from identifier, F0 returns to identifier
      unlock(); wr(UA0, 8'h90); wr(13'h0055, 8'h98);
      chk(mode_o == 3'd2, "R7", mode_o, 2);
      to_read();
      chk(mode_o == 3'd1, "R7", mode_o, 1);
      to_read();
      chk(mode_o == 3'd0, "R8", mode_o, 0);

      // R9 bypass: program without unlock, any address
      unlock(); wr(UA0, 8'h20);
      chk(mode_o == 3'd6 && bypass_o, "R9", mode_o, 6);
      wr(13'h0777, 8'hA0); wr(13'h0042, 8'h5A, 8'hF3);
      chk(prog_go && prog_word == 8'h52 && mode_o == 3'd6, "R9", prog_word, 8'h52);
      wr(13'h0001, 8'hA0); wr(13'h0043, 8'h0F);
      chk(prog_go && mode_o == 3'd6, "R9", mode_o, 6);
      // R9 erase from bypass returns to bypass
      wr(13'h0009, 8'h80); unlock(); wr(13'h0200, 8'h30);
      chk(erase_go && mode_o == 3'd5, "R9", mode_o, 5);
      @(negedge clk); erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
      chk(mode_o == 3'd6 && bypass_o, "R9", mode_o, 6);
      wr(13'h0003, 8'h90); wr(13'h0003, 8'h00);
      chk(mode_o == 3'd0 && !bypass_o, "R9", mode_o, 0);

      // R12 read pass-through outside identifier mode
      for (int o = 0; o < 32; o++) begin
         rd_addr = AW'(o * 2); arr_rdata = 8'(8'h3C ^ o);
         #1;
         chk(rd_data == arr_rdata, "R12", rd_data, arr_rdata);
      end
      // R11 identifier window sweep
      unlock(); wr(UA0, 8'h90);
      for (int o = 0; o < 64; o++) begin
         rd_addr = AW'(o * 2); arr_rdata = 8'(8'hA5 ^ o);
         #1;
         chk(rd_data == exp_id(8'(o), arr_rdata), "R11", rd_data, exp_id(8'(o), arr_rdata));
      end
      to_read();

      // R1 reset from a deep mode
      unlock(); wr(UA0, 8'h20);
      @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
      chk(mode_o == 3'd0 && !bypass_o, "R1", mode_o, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule